// File: doc/BRIEF.md
# Mode-Addressed Serial Control Port

This block is the control port of a frequency synthesizer. A host drives three wires (chip enable, serial clock and serial data in) and reads a fourth one, serial data out. While chip enable is low the host clocks in a four-bit mode code. The rising edge of chip enable fixes the mode. Three things can follow. The host can load the complete 36-bit control word, which is how every field gets initialised after power-up. It can load a 24-bit partial word that touches only the divider, output-port and counter-start fields. Or it can read back a status word made of the input-port lines, the general-purpose counter value and the loss-of-lock flag. Any other mode code makes the block ignore the whole transfer.

All three pins are brought into the system clock domain through two-flop synchronisers. The block finds serial-clock edges by comparing successive synchronised samples. A state machine tracks the transfer through five states:

- WAIT_MODE (`ST_ADDR`): collects mode bits.
- FULL_LOAD (`ST_WR_FULL`): shifts in a full word.
- PART_LOAD (`ST_WR_PART`): shifts in a partial word.
- READBACK (`ST_RD`): shifts status out.
- IGNORE (`ST_SKIP`): does nothing until the transfer ends.

The transitions are as follows:

- WAIT_MODE to FULL_LOAD, PART_LOAD, READBACK or IGNORE, on a chip-enable rise, according to the decoded code.
- Each of the four other states back to WAIT_MODE, on a chip-enable fall.
- A synchronous reset, which puts the machine in WAIT_MODE from any state.

Shifted data is committed only on the chip-enable fall, and only if the number of bits received was exactly right.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset all control outputs are zero and `ser_dout` is high.
- R2: Mode code 1 (bits sent LSB first as 1,0,0,0), followed by exactly 36 data bits, replaces the whole control word when chip enable falls. The first data bit lands in control bit 0. The word layout is `div_word` in bits 15:0, `port_out` in bits 22:16, `count_start` in bit 23 and `aux_cfg` in bits 35:24.
- R3: Mode code 2 (sent as 0,1,0,0), followed by exactly 24 data bits, updates bits 23:0 (divider, output port and counter start). `aux_cfg` keeps its previous value.
- R4: A write transfer with too few or too many data bits changes no control output.
- R5: Mode code 3 makes `ser_dout` present the status bits in this order: `stat_in_port[3:0]`, then `stat_count[19:0]`, then `stat_unlock`. Bit 0 appears after chip enable rises, and each serial-clock fall advances one bit. Once all 25 bits are out, `ser_dout` reads high.
- R6: Any mode code other than 1, 2 or 3 leaves the control outputs unchanged and `ser_dout` high, whatever bits follow.
- R7: `ser_dout` is high whenever no readback transfer is in progress.
- R8: Only the last four serial-clock bits before chip enable rises form the mode code. Bits clocked earlier in the same low phase have no effect.
- R9: The control outputs change only when a valid write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_ce | input | 1 | Chip enable from host |
| ser_clk | input | 1 | Serial clock from host |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial status data to host |
| stat_in_port | input | 4 | Input-port lines reported in readback |
| stat_count | input | 20 | General-purpose counter value reported in readback |
| stat_unlock | input | 1 | Loss-of-lock flag reported in readback |
| div_word | output | 16 | Programmable divider setting |
| port_out | output | 7 | Output-port levels |
| count_start | output | 1 | Counter start bit |
| aux_cfg | output | 12 | Remaining configuration bits (full write only) |

## Verification
The bench sends words that are one bit short and one bit long. A design that commits on any chip-enable fall would pick up a shifted or truncated word. It sends a partial update over a word whose upper field is all ones; a design that clears or shifts the upper twelve bits shows a changed `aux_cfg`. It sends mode codes preceded by extra leading bits. A design that keeps the first four bits, or that decodes the code MSB first, picks the wrong mode. Readback is checked bit by bit, including the bits past the end. An off-by-one advance, or a reversed field order, shows up as a wrong bit at some position.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

    localparam int MODE_BITS = 4;

    localparam logic [MODE_BITS-1:0] CODE_FULL = 4'd1;
    localparam logic [MODE_BITS-1:0] CODE_PART = 4'd2;
    localparam logic [MODE_BITS-1:0] CODE_READ = 4'd3;

    typedef enum logic [2:0] {
        ST_ADDR    = 3'd0,
        ST_WR_FULL = 3'd1,
        ST_WR_PART = 3'd2,
        ST_RD      = 3'd3,
        ST_SKIP    = 3'd4
    } port_state_e;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/scp_fsm.sv
module scp_fsm
    import serial_ctl_pkg::*;
#(
    parameter int FULL_W = 36,
    parameter int PART_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    output port_state_e       state,
    output logic              rd_next,
    output logic              ce_rise,
    output logic              sck_fall,
    output logic [FULL_W-1:0] wr_data,
    output logic              commit_full,
    output logic              commit_part
);

    localparam int CW = $clog2(FULL_W + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(FULL_W);
    localparam logic [CW-1:0] CNT_PART = CW'(PART_W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FULL_W + 1);

    port_state_e          state_q;
    port_state_e          state_d;
    logic                 ce_d;
    logic                 sck_d;
    logic                 ce_fall;
    logic                 sck_rise;
    logic [MODE_BITS-1:0] mode_sr;
    logic [CW-1:0]        bit_cnt;
    logic                 in_write;

    // edge detection on synchronised pins
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            ce_d  <= ce_s;
            sck_d <= sck_s;
        end
    end

    assign ce_rise  =  ce_s & ~ce_d;
    assign ce_fall  = ~ce_s &  ce_d;
    assign sck_rise =  sck_s & ~sck_d;
    assign sck_fall = ~sck_s &  sck_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ADDR;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ADDR: begin
                if (ce_rise) begin
                    if (mode_sr == CODE_FULL)      state_d = ST_WR_FULL;
                    else if (mode_sr == CODE_PART) state_d = ST_WR_PART;
                    else if (mode_sr == CODE_READ) state_d = ST_RD;
                    else                           state_d = ST_SKIP;
                end
            end
            ST_WR_FULL, ST_WR_PART, ST_RD, ST_SKIP: begin
                if (ce_fall) state_d = ST_ADDR;
            end
            default: state_d = ST_ADDR;
        endcase
    end

    // outputs
    always_comb begin
        commit_full = 1'b0;
        commit_part = 1'b0;
        in_write    = 1'b0;
        unique case (state_q)
            ST_WR_FULL: begin
                in_write    = 1'b1;
                commit_full = ce_fall && (bit_cnt == CNT_FULL);
            end
            ST_WR_PART: begin
                in_write    = 1'b1;
                commit_part = ce_fall && (bit_cnt == CNT_PART);
            end
            ST_ADDR, ST_RD, ST_SKIP: begin
                in_write = 1'b0;
            end
            default: in_write = 1'b0;
        endcase
    end

    assign state   = state_q;
    assign rd_next = (state_d == ST_RD);

    // mode code collection, LSB first, last four bits kept
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_sr <= '0;
        end else if (ce_fall) begin
            mode_sr <= '0;
        end else if (state_q == ST_ADDR && sck_rise) begin
            mode_sr <= {sdi_s, mode_sr[MODE_BITS-1:1]};
        end
    end

    // data bit counter, saturating one past a full word
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (ce_rise) begin
            bit_cnt <= '0;
        end else if (in_write && sck_rise && bit_cnt != CNT_SAT) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // per-bit capture of incoming data
    for (genvar i = 0; i < FULL_W; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                wr_data[i] <= 1'b0;
            end else if (in_write && sck_rise && bit_cnt == CW'(i)) begin
                wr_data[i] <= sdi_s;
            end
        end
    end

endmodule

// File: rtl/scp_ctrl_reg.sv
module scp_ctrl_reg #(
    parameter int FULL_W = 36,
    parameter int PART_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_full,
    input  logic              commit_part,
    input  logic [FULL_W-1:0] wr_data,
    output logic [FULL_W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (commit_full) begin
            ctrl_q <= wr_data;
        end else if (commit_part) begin
            ctrl_q[PART_W-1:0] <= wr_data[PART_W-1:0];
        end
    end

endmodule

// File: rtl/scp_status_tx.sv
module scp_status_tx #(
    parameter int STAT_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_next,
    input  logic              load,
    input  logic              advance,
    input  logic [STAT_W-1:0] status,
    output logic              dout
);

    logic [STAT_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '1;
        end else if (!rd_next) begin
            tx_sr <= '1;
        end else if (load) begin
            tx_sr <= status;
        end else if (advance) begin
            tx_sr <= {1'b1, tx_sr[STAT_W-1:1]};
        end
    end

    assign dout = tx_sr[0];

endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
    import serial_ctl_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int PORT_W = 7,
    parameter int AUX_W  = 12,
    parameter int IN_W   = 4,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_ce,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    input  logic [IN_W-1:0]   stat_in_port,
    input  logic [CNT_W-1:0]  stat_count,
    input  logic              stat_unlock,
    output logic [DIV_W-1:0]  div_word,
    output logic [PORT_W-1:0] port_out,
    output logic              count_start,
    output logic [AUX_W-1:0]  aux_cfg
);

    localparam int PART_W = DIV_W + PORT_W + 1;
    localparam int FULL_W = PART_W + AUX_W;
    localparam int STAT_W = IN_W + CNT_W + 1;

    logic [2:0]        pins_s;
    port_state_e       fsm_state;
    logic              rd_next;
    logic              ce_rise;
    logic              sck_fall;
    logic [FULL_W-1:0] wr_data;
    logic              commit_full;
    logic              commit_part;
    logic [FULL_W-1:0] ctrl_word;
    logic              load_stat;
    logic              adv_stat;

    scp_sync #(.W(3), .RST_VAL(3'b000)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_ce, ser_clk, ser_din}),
        .q   (pins_s)
    );

    scp_fsm #(.FULL_W(FULL_W), .PART_W(PART_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ce_s        (pins_s[2]),
        .sck_s       (pins_s[1]),
        .sdi_s       (pins_s[0]),
        .state       (fsm_state),
        .rd_next     (rd_next),
        .ce_rise     (ce_rise),
        .sck_fall    (sck_fall),
        .wr_data     (wr_data),
        .commit_full (commit_full),
        .commit_part (commit_part)
    );

    scp_ctrl_reg #(.FULL_W(FULL_W), .PART_W(PART_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .commit_full (commit_full),
        .commit_part (commit_part),
        .wr_data     (wr_data),
        .ctrl_q      (ctrl_word)
    );

    assign load_stat = ce_rise && (fsm_state == ST_ADDR);
    assign adv_stat  = sck_fall && (fsm_state == ST_RD);

    scp_status_tx #(.STAT_W(STAT_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .rd_next (rd_next),
        .load    (load_stat),
        .advance (adv_stat),
        .status  ({stat_unlock, stat_count, stat_in_port}),
        .dout    (ser_dout)
    );

    assign div_word    = ctrl_word[DIV_W-1:0];
    assign port_out    = ctrl_word[DIV_W+PORT_W-1:DIV_W];
    assign count_start = ctrl_word[PART_W-1];
    assign aux_cfg     = ctrl_word[FULL_W-1:PART_W];

endmodule

// File: rtl/scp_checker.sv
module scp_checker
    import serial_ctl_pkg::*;
#(
    parameter int FULL_W = 36,
    parameter int PART_W = 24
) (
    input logic              clk,
    input logic              rst,
    input port_state_e       fsm_state,
    input logic              commit_full,
    input logic              commit_part,
    input logic [FULL_W-1:0] ctrl_word,
    input logic              sck_fall,
    input logic              ser_dout
);

    // R7
    dout_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_state != ST_RD && $past(fsm_state) != ST_RD) |-> ser_dout);

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit_full && !commit_part) |=> $stable(ctrl_word));

    // R3
    part_keep_chk: assert property (@(posedge clk) disable iff (rst)
        commit_part |=> ctrl_word[FULL_W-1:PART_W] == $past(ctrl_word[FULL_W-1:PART_W]));

    // R5
    dout_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_RD && $past(fsm_state) == ST_RD && !$past(sck_fall))
            |-> $stable(ser_dout));

    // R2
    commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit_full, commit_part}));

endmodule

bind serial_ctl_port scp_checker #(.FULL_W(FULL_W), .PART_W(PART_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fsm_state   (fsm_state),
    .commit_full (commit_full),
    .commit_part (commit_part),
    .ctrl_word   (ctrl_word),
    .sck_fall    (sck_fall),
    .ser_dout    (ser_dout)
);

// File: tb/serial_ctl_port_test.sv
module serial_ctl_port_test;

    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_ce = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic [3:0]  stat_in_port = '0;
    logic [19:0] stat_count = '0;
    logic        stat_unlock = 1'b0;
    logic [15:0] div_word;
    logic [6:0]  port_out;
    logic        count_start;
    logic [11:0] aux_cfg;

    int vectors = 0;
    int fails = 0;
    logic [35:0] exp_ctrl = '0;
    logic        dout_idle = 1'b1;

    always #5 clk = ~clk;

    serial_ctl_port uut (
        .clk          (clk),
        .rst          (rst),
        .ser_ce       (ser_ce),
        .ser_clk      (ser_clk),
        .ser_din      (ser_din),
        .ser_dout     (ser_dout),
        .stat_in_port (stat_in_port),
        .stat_count   (stat_count),
        .stat_unlock  (stat_unlock),
        .div_word     (div_word),
        .port_out     (port_out),
        .count_start  (count_start),
        .aux_cfg      (aux_cfg)
    );

    function automatic logic [35:0] ctrl_now();
        return {aux_cfg, count_start, port_out, div_word};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        ser_din = b;
        tick(H);
        ser_clk = 1'b1;
        tick(H);
        ser_clk = 1'b0;
    endtask

    // every-clock comparison against the reference model (R9, R7)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9", {28'd0, ctrl_now()}, {28'd0, exp_ctrl});
            if (dout_idle) chk("R7", {63'd0, ser_dout}, 64'd1);
        end
    end

    task automatic xfer(input logic [3:0] code, input int pre,
                        input logic [35:0] data, input int n);
        for (int i = 0; i < pre; i++) put_bit(1'b1);
        for (int i = 0; i < 4; i++) put_bit(code[i]);
        tick(H);
        ser_ce = 1'b1;
        tick(H);
        for (int i = 0; i < n; i++) put_bit(i < 36 ? data[i] : 1'b0);
        tick(H);
        ser_ce = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        if (code == 4'd1 && n == 36)      exp_ctrl = data;
        else if (code == 4'd2 && n == 24) exp_ctrl[23:0] = data[23:0];
        tick(H);
    endtask

    task automatic readback(input logic [3:0] ip, input logic [19:0] cv, input logic ul);
        logic [24:0] st;
        stat_in_port = ip;
        stat_count   = cv;
        stat_unlock  = ul;
        st = {ul, cv, ip};
        for (int i = 0; i < 4; i++) put_bit(i < 2 ? 1'b1 : 1'b0);
        tick(H);
        dout_idle = 1'b0;
        ser_ce = 1'b1;
        tick(H);
        for (int k = 0; k < 28; k++) begin
            // R5: bit k of status, then ones
            chk("R5", {63'd0, ser_dout}, {63'd0, (k < 25) ? st[k] : 1'b1});
            ser_clk = 1'b1;
            tick(H);
            ser_clk = 1'b0;
            tick(H);
        end
        ser_ce = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        dout_idle = 1'b1;
        tick(H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1
        chk("R1", {28'd0, ctrl_now()}, 64'd0);
        chk("R1", {63'd0, ser_dout}, 64'd1);

        // R2: full writes, two patterns
        xfer(4'd1, 0, 36'h9_A5C3_1E7B, 36);
        chk("R2", {28'd0, ctrl_now()}, 64'h9_A5C3_1E7B);
        xfer(4'd1, 0, 36'hF_FFF0_0001, 36);
        chk("R2", {52'd0, aux_cfg}, 64'hFFF);
        chk("R2", {48'd0, div_word}, 64'h0001);

        // R3: partial write keeps aux_cfg
        xfer(4'd2, 0, 36'h0_00D2_5A33, 24);
        chk("R3", {52'd0, aux_cfg}, 64'hFFF);
        chk("R3", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);

        // R4: short and long transfers discarded
        xfer(4'd1, 0, 36'h1_2345_6789, 35);
        chk("R4", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);
        xfer(4'd1, 0, 36'h1_2345_6789, 37);
        chk("R4", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);
        xfer(4'd2, 0, 36'h0_0011_1111, 23);
        chk("R4", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);
        xfer(4'd2, 0, 36'h0_0011_1111, 36);
        chk("R4", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);

        // R6: invalid codes
        xfer(4'd0, 0, 36'h5_5555_5555, 36);
        chk("R6", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);
        xfer(4'd8, 0, 36'h5_5555_5555, 36);
        chk("R6", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);
        xfer(4'd15, 0, 36'h0_0055_5555, 24);
        chk("R6", {28'd0, ctrl_now()}, 64'hF_FFD2_5A33);
        chk("R6", {63'd0, ser_dout}, 64'd1);

        // R8: extra leading bits before the code
        xfer(4'd1, 3, 36'h0_1234_ABCD, 36);
        chk("R8", {28'd0, ctrl_now()}, 64'h0_1234_ABCD);
        xfer(4'd2, 2, 36'h0_0080_0000, 24);
        chk("R8", {28'd0, ctrl_now()}, 64'h0_1280_0000);

        // R5: readback, two patterns
        readback(4'hA, 20'h8_1F3C, 1'b1);
        readback(4'h5, 20'h0_0001, 1'b0);
        chk("R7", {63'd0, ser_dout}, 64'd1);
        chk("R5", {28'd0, ctrl_now()}, 64'h0_1280_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule